// File: doc/BRIEF.md
# Branch Condition Flag Unit

This unit keeps the four arithmetic condition flags of a 32-bit load/store processor: negative, zero, carry and overflow. The flags are updated from the ALU's operands and result whenever the flag-write enable is high. The kind of operation decides which flags change. Add and subtract refresh all four flags. Logical operations and moves refresh only the negative and zero flags.

Alongside the flags, the unit evaluates a 4-bit branch condition against the stored flags and registers a taken or not-taken decision. It also presents the flags as a zero-extended word, so that a read-status operation can move them into an ordinary register.

The ALU, branch target arithmetic and pipeline control sit outside this block.

Top module: `cond_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags, makes `status_word` zero and makes `br_taken` 0.
- R2: When `flag_we` is 0, the flags (and so `status_word`) keep their value at the clock edge, whatever the other inputs are.
- R3: On a flag write of any operation kind, N becomes bit 31 of `alu_res`, and Z becomes 1 exactly when `alu_res` is all zeros.
- R4: For `op_kind` 0 (add), C becomes the carry out of bit 31 of `opnd_a + opnd_b`.
- R5: For `op_kind` 1 (subtract, `opnd_a - opnd_b`), C becomes the borrow, that is 1 exactly when `opnd_a < opnd_b` unsigned.
- R6: For add and subtract, V becomes 1 exactly when the result overflows as a two's complement value, and becomes 0 otherwise.
- R7: For `op_kind` 2 (logical) and 3 (move), C and V keep their previous values.
- R8: With `cond_sel[3]` = 0, `cond_sel[2:0]` selects the base test: 0 = N, 1 = Z, 2 = C, 3 = V, 4 = C or Z (unsigned lower-or-same), 5 = N xor V (signed less-than), 6 = (N xor V) or Z (signed less-or-equal), 7 = always.
- R9: With `cond_sel[3]` = 1, the decision is the inverse of the base test, so code 15 is never taken.
- R10: `status_word` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0, and zeros in bits 31 to 4.
- R11: `br_taken` is registered: after a clock edge, it gives the decision for the `cond_sel` that was present at that edge, tested against the flags held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | Flag update enable |
| op_kind | input | 2 | 0 add, 1 subtract, 2 logical, 3 move |
| opnd_a | input | 32 | First ALU operand |
| opnd_b | input | 32 | Second ALU operand |
| alu_res | input | 32 | ALU result |
| cond_sel | input | 4 | Branch condition: bit 3 negates, bits 2:0 pick the base test |
| br_taken | output | 1 | Registered branch decision |
| status_word | output | 32 | Flags packed for a register read |

## Verification
Adds are tried across three boundaries: the unsigned wrap to zero, the signed overflow into the sign bit, and two negatives whose sum overflows. Together they separate carry from overflow and show the zero flag firing on a wrapped result. Subtracts are tried with a smaller minuend, with equal operands and with the most negative value minus one, which separate borrow, zero and overflow from one another. After each of these flag states, all sixteen condition codes are evaluated against a bench model, so that each compound relation and its negated twin are told apart. Logical results, writes with the enable low and a same-cycle flag write plus condition show the preserved carry and overflow, the hold behaviour and the one-edge ordering.

// File: rtl/cond_pkg.sv
package cond_pkg;

  typedef enum logic [1:0] {
    OPK_ADD   = 2'd0,
    OPK_SUB   = 2'd1,
    OPK_LOGIC = 2'd2,
    OPK_MOVE  = 2'd3
  } opk_e;

  // Packed so that n lands in bit 3 and v in bit 0 of the status word.
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import cond_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  opk_e              op_kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  flags_t            cur,
  output flags_t            nxt
);
  localparam int unsigned MSB = DATA_W - 1;

  logic a_s, b_s, r_s;
  logic add_c, add_v, sub_c, sub_v;

  always_comb begin
    a_s = opnd_a[MSB];
    b_s = opnd_b[MSB];
    r_s = alu_res[MSB];
    // The carry and borrow out of the top bit follow from the sign bits of
    // the operands and the result, so no second adder is needed here.
    add_c = (a_s & b_s) | ((a_s | b_s) & ~r_s);
    add_v = (a_s == b_s) & (r_s != a_s);
    sub_c = (~a_s & b_s) | ((~a_s | b_s) & r_s);
    sub_v = (a_s != b_s) & (r_s != a_s);
  end

  always_comb begin
    nxt   = cur;
    nxt.n = r_s;
    nxt.z = (alu_res == '0);
    unique case (op_kind)
      OPK_ADD: begin
        nxt.c = add_c;
        nxt.v = add_v;
      end
      OPK_SUB: begin
        nxt.c = sub_c;
        nxt.v = sub_v;
      end
      default: begin
        nxt.c = cur.c;
        nxt.v = cur.v;
      end
    endcase
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import cond_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  flags_t d,
  output flags_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
#(
  parameter int unsigned COND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  flags_t            flg,
  input  logic [COND_W-1:0] cond_sel,
  output logic              taken
);
  localparam int unsigned SEL_W    = COND_W - 1;
  localparam int unsigned NUM_BASE = 2 ** SEL_W;

  logic [NUM_BASE-1:0] base_vec;
  logic                lt_signed;
  logic                pick;

  assign lt_signed = flg.n ^ flg.v;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BASE; gi++) begin : g_base
      if (gi == 0) begin : g_n
        assign base_vec[gi] = flg.n;
      end else if (gi == 1) begin : g_z
        assign base_vec[gi] = flg.z;
      end else if (gi == 2) begin : g_c
        assign base_vec[gi] = flg.c;
      end else if (gi == 3) begin : g_v
        assign base_vec[gi] = flg.v;
      end else if (gi == 4) begin : g_ls
        assign base_vec[gi] = flg.c | flg.z;
      end else if (gi == 5) begin : g_lt
        assign base_vec[gi] = lt_signed;
      end else if (gi == 6) begin : g_le
        assign base_vec[gi] = lt_signed | flg.z;
      end else begin : g_al
        assign base_vec[gi] = 1'b1;
      end
    end
  endgenerate

  assign pick = base_vec[cond_sel[SEL_W-1:0]] ^ cond_sel[SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      taken <= 1'b0;
    end else begin
      taken <= pick;
    end
  end

endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cond_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_we,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [COND_W-1:0] cond_sel,
  output logic              br_taken,
  output logic [DATA_W-1:0] status_word
);
  localparam int unsigned PAD_W = DATA_W - FLAG_W;

  flags_t flg_q, flg_d;

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op_kind (opk_e'(op_kind)),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .alu_res (alu_res),
    .cur     (flg_q),
    .nxt     (flg_d)
  );

  flag_reg u_freg (
    .clk (clk),
    .rst (rst),
    .we  (flag_we),
    .d   (flg_d),
    .q   (flg_q)
  );

  cond_eval #(.COND_W(COND_W)) u_eval (
    .clk      (clk),
    .rst      (rst),
    .flg      (flg_q),
    .cond_sel (cond_sel),
    .taken    (br_taken)
  );

  assign status_word = {{PAD_W{1'b0}}, flg_q};

endmodule

// File: rtl/cond_unit_chk.sv
module cond_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned COND_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              flag_we,
  input logic [1:0]        op_kind,
  input logic [DATA_W-1:0] alu_res,
  input logic [COND_W-1:0] cond_sel,
  input logic              br_taken,
  input logic [DATA_W-1:0] status_word
);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (status_word == '0) && !br_taken);

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(status_word));

  // R3
  p_zero_flag_r3: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> status_word[2] == ($past(alu_res) == '0));

  // R7
  p_logic_keeps_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_kind[1]) |=> status_word[1:0] == $past(status_word[1:0]));

  // R8
  p_always_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'h7) |=> br_taken);

  // R9
  p_never_r9: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'hF) |=> !br_taken);

  // R10
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    status_word[DATA_W-1:4] == '0);

endmodule

bind cond_unit cond_unit_chk #(.DATA_W(DATA_W), .COND_W(COND_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flag_we     (flag_we),
  .op_kind     (op_kind),
  .alu_res     (alu_res),
  .cond_sel    (cond_sel),
  .br_taken    (br_taken),
  .status_word (status_word)
);

// File: tb/sim_cond_unit.sv
module sim_cond_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flag_we = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
  logic [3:0]  cond_sel = 4'h0;
  logic        br_taken;
  logic [31:0] status_word;

  int checks = 0;
  int fails  = 0;
  logic [3:0] mflg = 4'h0;  // model: {N,Z,C,V}

  always #2 clk = ~clk;

  cond_unit u0 (
    .clk(clk), .rst(rst), .flag_we(flag_we), .op_kind(op_kind),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
    .cond_sel(cond_sel), .br_taken(br_taken), .status_word(status_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_cond(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v, b;
    {n, z, cy, v} = f;
    case (c[2:0])
      3'd0: b = n;
      3'd1: b = z;
      3'd2: b = cy;
      3'd3: b = v;
      3'd4: b = cy | z;
      3'd5: b = n ^ v;
      3'd6: b = (n ^ v) | z;
      default: b = 1'b1;
    endcase
    return b ^ c[3];
  endfunction

  // Drive one flag write and update the bench model independently.
  task automatic do_op(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] r_logic);
    logic [32:0] wide;
    logic [31:0] r;
    logic n, z, cy, v;
    cy = mflg[1];
    v  = mflg[0];
    if (k == 2'd0) begin
      wide = {1'b0, a} + {1'b0, b};
      r = wide[31:0];
      cy = wide[32];
      v = ($signed(a) + $signed(b)) != ($signed({a[31], a}) + $signed({b[31], b}));
      v = (a[31] == b[31]) && (r[31] != a[31]);
    end else if (k == 2'd1) begin
      r = a - b;
      cy = (a < b);
      v = (a[31] != b[31]) && (r[31] != a[31]);
    end else begin
      r = r_logic;
    end
    n = r[31];
    z = (r == 32'd0);
    @(negedge clk);
    flag_we = 1'b1; op_kind = k; opnd_a = a; opnd_b = b; alu_res = r;
    @(negedge clk);
    flag_we = 1'b0;
    mflg = {n, z, cy, v};
  endtask

  task automatic check_flags(input string req);
    chk(req, status_word, {28'd0, mflg});
  endtask

  task automatic sweep_conds(input string tag);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond_sel = 4'(c);
      @(posedge clk); #1;
      chk($sformatf("R8/R9 %s code %0d", tag, c), {31'd0, br_taken},
          {31'd0, model_cond(mflg, 4'(c))});
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status_word, 32'd0);
    chk("R1 taken", {31'd0, br_taken}, 32'd0);
    sweep_conds("reset");
  endtask

  task automatic t_add();
    do_op(2'd0, 32'hFFFF_FFFF, 32'h1, '0);
    check_flags("R4 R3 add wrap");
    chk("R4 status exact", status_word, 32'h6);
    sweep_conds("add wrap");
    do_op(2'd0, 32'h7FFF_FFFF, 32'h1, '0);
    check_flags("R6 add overflow");
    chk("R6 status exact", status_word, 32'h9);
    sweep_conds("add ovf");
    do_op(2'd0, 32'hFFFF_FFFF, 32'h8000_0000, '0);
    check_flags("R4 R6 neg+neg");
    chk("R10 layout C and V", status_word, 32'h3);
    sweep_conds("neg+neg");
  endtask

  task automatic t_logic();
    do_op(2'd2, '0, '0, 32'h0);
    check_flags("R7 logic zero");
    chk("R7 keeps C V", status_word, 32'h7);
    do_op(2'd3, '0, '0, 32'h8000_0000);
    chk("R7 move keeps C V", status_word, 32'hB);
    sweep_conds("logic");
  endtask

  task automatic t_sub();
    do_op(2'd1, 32'd3, 32'd5, '0);
    check_flags("R5 borrow");
    chk("R5 status exact", status_word, 32'hA);
    sweep_conds("sub lt");
    do_op(2'd1, 32'd5, 32'd5, '0);
    check_flags("R5 equal");
    chk("R5 equal exact", status_word, 32'h4);
    sweep_conds("sub eq");
    do_op(2'd1, 32'h8000_0000, 32'd1, '0);
    check_flags("R6 sub overflow");
    chk("R6 sub exact", status_word, 32'h1);
    sweep_conds("sub ovf");
  endtask

  task automatic t_hold();
    @(negedge clk);
    flag_we = 1'b0; op_kind = 2'd0; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; alu_res = 32'h0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R2 hold", status_word, {28'd0, mflg});
  endtask

  task automatic t_timing();
    // Flags now Z=0; write a zero result and ask for Z in the same cycle.
    @(negedge clk);
    flag_we = 1'b1; op_kind = 2'd2; alu_res = 32'h0; cond_sel = 4'h1;
    @(posedge clk); #1;
    chk("R11 old flags used", {31'd0, br_taken}, 32'd0);
    @(negedge clk);
    flag_we = 1'b0;
    mflg = {1'b0, 1'b1, mflg[1], mflg[0]};
    @(posedge clk); #1;
    chk("R11 new flags next", {31'd0, br_taken}, 32'd1);
    chk("R3 zero set", status_word, {28'd0, mflg});
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1; cond_sel = 4'h7;
    @(posedge clk); #1;
    chk("R1 re-reset status", status_word, 32'd0);
    chk("R1 re-reset taken", {31'd0, br_taken}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    mflg = 4'h0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_add();
    t_logic();
    t_sub();
    t_hold();
    t_timing();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule